// File: doc/BRIEF.md
# Multi-Stage Sequential Trigger Engine

This block watches a 16-channel sample stream and decides when a capture trigger should fire. Software programs a chain of up to 16 stages. Each stage holds two channel comparisons. A comparison can test levels, rising edges, falling edges or any change, and it can test several channels in one sample. The two results are joined by AND or OR. A stage also holds an occurrence count: the joined condition must be seen on that many valid samples before the chain moves on to the next stage.

The sequence starts when the block is armed. It then walks the stages in order, and only samples marked valid are evaluated. When the last active stage completes, the trigger flag is set and stays set until the block is armed again. The same event starts a pulse of programmable width on a separate trigger-out pin. A pulse that is already running cannot be extended or restarted.

Top module: `trig_seq_engine`

## Requirements
- R1: After synchronous reset, `trig` and `trig_out` are low. All stage settings clear to zero, and the global setting clears to one active stage and a pulse width of one.
- R2: Settings are written with `cfg_we`. `cfg_stage` selects the stage and `cfg_field` selects the register: 0 care mask A, 1 level A, 2 edge select A, 3 care mask B, 4 level B, 5 edge select B, 6 stage control (bits 15:0 occurrence count, bit 16 OR-join), 7 global (bits 4:0 active stage count, bits 23:16 pulse width; `cfg_stage` ignored). A channel whose care bit is 0 always matches. A cared channel in level mode matches when the sample bit equals the level bit.
- R3: The edge select word holds 2 bits per channel, channel i at bits 2i+1:2i. The codes are 0 level, 1 rising, 2 falling, 3 either edge, and each is judged against the previous valid sample. Edges on several channels are required together when several channels select edges.
- R4: On the first valid sample after arming, no edge is seen, so any cared channel in an edge mode fails.
- R5: With OR-join clear, a stage condition needs both comparisons true. With OR-join set, either one is enough.
- R6: A stage completes on the N-th valid sample, not necessarily consecutive, on which its condition holds, where N is its occurrence count and a count of 0 acts as 1. Samples with `smp_valid` low are ignored.
- R7: Stages are visited in order from stage 0. The trigger fires when the last active stage completes, in the same cycle. An active stage count of 0 acts as 1, and a count above 16 acts as 16.
- R8: Once set, `trig` stays high and further samples have no effect until `arm` is pulsed. The cycle after `arm`, `trig` is low.
- R9: Arming returns the sequence to stage 0, clears the occurrence counter and forgets the previous sample.
- R10: `trig_out` rises in the same cycle as `trig` and stays high for W clock cycles, where W is the pulse width and a width of 0 acts as 1.
- R11: A trigger that arrives while a trigger-out pulse is still running neither extends nor restarts it. `arm` does not cut a running pulse short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Restart the sequence and clear the trigger |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Channel sample |
| cfg_we | input | 1 | Setting write enable |
| cfg_stage | input | 4 | Stage selected for the write |
| cfg_field | input | 3 | Register selected for the write |
| cfg_wdata | input | 32 | Write data |
| trig | output | 1 | Trigger flag, held until re-armed |
| trig_out | output | 1 | Trigger-out pulse |

## Verification
Level patterns with half the channels masked show that don't-care bits are ignored. The edge tests separate a single either-edge channel from a rising and falling pair that must occur in one sample, and they show that the first sample after arming can never produce an edge. Samples that satisfy only one of two comparisons tell AND from OR. Out-of-order stage matches, idle strobes and a re-arm in the middle of a chain show that the pointer and the counter advance only as required. Pulse tests with widths 3, 0 and 10 measure how wide trig_out is and confirm that a second trigger does not restart a running pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;
    parameter int NCH   = 16;
    parameter int NSTG  = 16;
    parameter int CNT_W = 16;
    parameter int PW_W  = 8;
    parameter int CFG_W = 32;

    localparam int STG_W      = $clog2(NSTG);
    localparam int NSTG_W     = $clog2(NSTG + 1);
    localparam int OR_BIT     = CNT_W;
    localparam int PW_LSB     = 16;
    localparam int EDGE_W     = 2 * NCH;

    typedef enum logic [1:0] {
        EDG_LEVEL = 2'd0,
        EDG_RISE  = 2'd1,
        EDG_FALL  = 2'd2,
        EDG_ANY   = 2'd3
    } edge_sel_e;

    typedef enum logic [2:0] {
        F_A_CARE  = 3'd0,
        F_A_LEVEL = 3'd1,
        F_A_EDGE  = 3'd2,
        F_B_CARE  = 3'd3,
        F_B_LEVEL = 3'd4,
        F_B_EDGE  = 3'd5,
        F_CTRL    = 3'd6,
        F_GLOBAL  = 3'd7
    } cfg_field_e;

    typedef struct packed {
        logic [NCH-1:0]    care;
        logic [NCH-1:0]    level;
        logic [EDGE_W-1:0] edges;
    } cmp_cfg_t;

    typedef struct packed {
        cmp_cfg_t [1:0]    cmp;
        logic              use_or;
        logic [CNT_W-1:0]  need;
    } stage_cfg_t;

    // Per-channel match: don't-care passes, edges need a valid previous sample.
    function automatic logic chan_hit(input logic cur, input logic prev,
                                      input logic prev_ok, input logic care,
                                      input logic level, input logic [1:0] sel);
        logic r;
        if (!care) begin
            r = 1'b1;
        end else begin
            case (edge_sel_e'(sel))
                EDG_LEVEL: r = (cur == level);
                EDG_RISE:  r = prev_ok & ~prev & cur;
                EDG_FALL:  r = prev_ok & prev & ~cur;
                default:   r = prev_ok & (prev ^ cur);
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [STG_W-1:0]        cfg_stage,
    input  logic [2:0]              cfg_field,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output stage_cfg_t              stg [NSTG],
    output logic [STG_W-1:0]        last_stage,
    output logic [PW_W-1:0]         pulse_len
);
    logic [NSTG_W-1:0] raw_cnt;
    assign raw_cnt = cfg_wdata[NSTG_W-1:0];

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[s] <= '0;
            end else if (cfg_we && cfg_stage == STG_W'(s)) begin
                case (cfg_field_e'(cfg_field))
                    F_A_CARE:  stg[s].cmp[0].care  <= cfg_wdata[NCH-1:0];
                    F_A_LEVEL: stg[s].cmp[0].level <= cfg_wdata[NCH-1:0];
                    F_A_EDGE:  stg[s].cmp[0].edges <= cfg_wdata[EDGE_W-1:0];
                    F_B_CARE:  stg[s].cmp[1].care  <= cfg_wdata[NCH-1:0];
                    F_B_LEVEL: stg[s].cmp[1].level <= cfg_wdata[NCH-1:0];
                    F_B_EDGE:  stg[s].cmp[1].edges <= cfg_wdata[EDGE_W-1:0];
                    F_CTRL: begin
                        stg[s].need   <= cfg_wdata[CNT_W-1:0];
                        stg[s].use_or <= cfg_wdata[OR_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_stage <= '0;
            pulse_len  <= '0;
        end else if (cfg_we && cfg_field_e'(cfg_field) == F_GLOBAL) begin
            pulse_len <= cfg_wdata[PW_LSB +: PW_W];
            if (raw_cnt == '0)
                last_stage <= '0;
            else if (raw_cnt > NSTG_W'(NSTG))
                last_stage <= STG_W'(NSTG - 1);
            else
                last_stage <= STG_W'(raw_cnt - 1'b1);
        end
    end
endmodule

// File: rtl/trig_cmp.sv
module trig_cmp
    import trig_pkg::*;
(
    input  cmp_cfg_t        cfg,
    input  logic [NCH-1:0]  cur,
    input  logic [NCH-1:0]  prev,
    input  logic            prev_ok,
    output logic            hit
);
    logic [NCH-1:0] per_chan;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            per_chan[i] = chan_hit(cur[i], prev[i], prev_ok, cfg.care[i],
                                   cfg.level[i], cfg.edges[2*i +: 2]);
        end
    end

    assign hit = &per_chan;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                smp_valid,
    input  logic [NCH-1:0]      smp_data,
    input  stage_cfg_t          stg [NSTG],
    input  logic [STG_W-1:0]    last_stage,
    output logic                trig,
    output logic                fire
);
    logic [STG_W-1:0]  ptr;
    logic [CNT_W-1:0]  hits;
    logic [NCH-1:0]    prev;
    logic              prev_ok;
    stage_cfg_t        cur_cfg;
    logic [1:0]        cmp_hit;
    logic              cond;
    logic [CNT_W:0]    hits_nx;
    logic [CNT_W:0]    need_eff;
    logic              reached;
    logic              at_last;

    assign cur_cfg = stg[ptr];

    for (genvar c = 0; c < 2; c++) begin : g_cmp
        trig_cmp u_cmp (
            .cfg     (cur_cfg.cmp[c]),
            .cur     (smp_data),
            .prev    (prev),
            .prev_ok (prev_ok),
            .hit     (cmp_hit[c])
        );
    end

    assign cond     = cur_cfg.use_or ? (|cmp_hit) : (&cmp_hit);
    assign hits_nx  = {1'b0, hits} + (CNT_W+1)'(1);
    assign need_eff = (cur_cfg.need == '0) ? (CNT_W+1)'(1) : {1'b0, cur_cfg.need};
    assign reached  = (hits_nx >= need_eff);
    assign at_last  = (ptr >= last_stage);
    assign fire     = smp_valid && !trig && !arm && cond && reached && at_last;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            ptr     <= '0;
            hits    <= '0;
            prev    <= '0;
            prev_ok <= 1'b0;
            trig    <= 1'b0;
        end else begin
            if (smp_valid) begin
                prev    <= smp_data;
                prev_ok <= 1'b1;
            end
            if (smp_valid && !trig && cond) begin
                if (reached) begin
                    hits <= '0;
                    if (at_last) trig <= 1'b1;
                    else         ptr  <= ptr + 1'b1;
                end else begin
                    hits <= hits_nx[CNT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/trig_pulse.sv
module trig_pulse
    import trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [PW_W-1:0]  len,
    output logic [PW_W-1:0]  cnt,
    output logic             pulse
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
        else if (fire)
            cnt <= (len == '0) ? PW_W'(1) : len;
    end

    assign pulse = (cnt != '0);
endmodule

// File: rtl/trig_seq_engine.sv
module trig_seq_engine
    import trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               arm,
    input  logic               smp_valid,
    input  logic [NCH-1:0]     smp_data,
    input  logic               cfg_we,
    input  logic [STG_W-1:0]   cfg_stage,
    input  logic [2:0]         cfg_field,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic               trig,
    output logic               trig_out
);
    stage_cfg_t        stg [NSTG];
    logic [STG_W-1:0]  last_stage;
    logic [PW_W-1:0]   pulse_len;
    logic [PW_W-1:0]   pulse_cnt;
    logic              fire;

    trig_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_stage  (cfg_stage),
        .cfg_field  (cfg_field),
        .cfg_wdata  (cfg_wdata),
        .stg        (stg),
        .last_stage (last_stage),
        .pulse_len  (pulse_len)
    );

    trig_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .stg        (stg),
        .last_stage (last_stage),
        .trig       (trig),
        .fire       (fire)
    );

    trig_pulse u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .len   (pulse_len),
        .cnt   (pulse_cnt),
        .pulse (trig_out)
    );
endmodule

// File: rtl/trig_seq_engine_chk.sv
module trig_seq_engine_chk
    import trig_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             arm,
    input logic             smp_valid,
    input logic             trig,
    input logic             trig_out,
    input logic [PW_W-1:0]  pulse_cnt
);
    // R8: trigger is sticky until arm
    a_r8_trig_holds: assert property (@(posedge clk) disable iff (rst)
        (trig && !arm) |=> trig);

    // R8: arming drops the trigger
    a_r8_arm_clears: assert property (@(posedge clk) disable iff (rst)
        arm |=> !trig);

    // R6: only a valid sample can complete the sequence
    a_r6_fire_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !trig) |=> !trig);

    // R10: trigger-out is high whenever the trigger first sets
    a_r10_out_with_trig: assert property (@(posedge clk) disable iff (rst)
        $rose(trig) |-> trig_out);

    // R10: a new pulse only starts with a new trigger
    a_r10_out_from_trig: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_out) |-> $rose(trig));

    // R11: a running pulse only counts down, never reloads
    a_r11_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (pulse_cnt != '0) |=> (pulse_cnt == PW_W'($past(pulse_cnt) - 1'b1)));
endmodule

bind trig_seq_engine trig_seq_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .smp_valid (smp_valid),
    .trig      (trig),
    .trig_out  (trig_out),
    .pulse_cnt (pulse_cnt)
);

// File: tb/trig_seq_engine_test.sv
module trig_seq_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_stage = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        trig;
    logic        trig_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_seq_engine uut (
        .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .trig(trig), .trig_out(trig_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] d);
        @(negedge clk);
        smp_valid = v;
        smp_data  = d;
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(posedge clk);
        #1;
        arm = 1'b0;
    endtask

    task automatic wr(input logic [3:0] s, input logic [2:0] f, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stage = s; cfg_field = f; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_stage(input logic [3:0] s, input logic [15:0] ac, input logic [15:0] al,
                             input logic [31:0] ae, input logic [15:0] bc, input logic [15:0] bl,
                             input logic [31:0] be, input logic use_or, input logic [15:0] n);
        wr(s, 3'd0, {16'h0, ac});
        wr(s, 3'd1, {16'h0, al});
        wr(s, 3'd2, ae);
        wr(s, 3'd3, {16'h0, bc});
        wr(s, 3'd4, {16'h0, bl});
        wr(s, 3'd5, be);
        wr(s, 3'd6, {15'h0, use_or, n});
    endtask

    task automatic set_global(input logic [4:0] nstg, input logic [7:0] w);
        wr(4'd0, 3'd7, {8'h0, w, 11'h0, nstg});
    endtask

    task automatic settle();
        for (int i = 0; i < 12; i++) step(1'b0, 16'h0);
    endtask

    task automatic t_reset();
        check("R1 trig after reset", trig, 1'b0);
        check("R1 trig_out after reset", trig_out, 1'b0);
        // default: one stage, all care bits 0, count 0 -> any valid sample fires
        do_arm();
        step(1'b1, 16'h1234);
        check("R1 default config fires on first sample", trig, 1'b1);
        check("R1 default pulse width 1", trig_out, 1'b1);
        step(1'b0, 16'h0);
        check("R1 default pulse ends", trig_out, 1'b0);
    endtask

    task automatic t_level();
        set_stage(4'd0, 16'h00FF, 16'h00A5, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        set_global(5'd1, 8'd3);
        do_arm();
        step(1'b1, 16'h12A4);
        check("R2 masked mismatch no trig", trig, 1'b0);
        step(1'b1, 16'hFFA5);
        check("R2 don't-care upper bits trig", trig, 1'b1);
        check("R10 trig_out rises with trig", trig_out, 1'b1);
        step(1'b0, 16'h0);
        check("R10 width3 cycle2", trig_out, 1'b1);
        step(1'b0, 16'h0);
        check("R10 width3 cycle3", trig_out, 1'b1);
        step(1'b0, 16'h0);
        check("R10 width3 ends", trig_out, 1'b0);
    endtask

    task automatic t_edge();
        // ch0 either edge (code 3 at bits 1:0)
        set_stage(4'd0, 16'h0001, 16'h0, 32'h3, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        set_global(5'd1, 8'd1);
        do_arm();
        step(1'b1, 16'h0001);
        check("R4 no edge on first sample", trig, 1'b0);
        step(1'b1, 16'h0001);
        check("R3 no change no edge", trig, 1'b0);
        step(1'b1, 16'h0000);
        check("R3 either edge detected", trig, 1'b1);
        // ch0 rising (1), ch1 falling (2 at bits 3:2) together
        set_stage(4'd0, 16'h0003, 16'h0, 32'h9, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        do_arm();
        step(1'b1, 16'h0002);
        check("R4 first sample after arm", trig, 1'b0);
        step(1'b1, 16'h0003);
        check("R3 rise alone not enough", trig, 1'b0);
        step(1'b1, 16'h0002);
        check("R3 wrong direction", trig, 1'b0);
        step(1'b1, 16'h0001);
        check("R3 simultaneous rise and fall", trig, 1'b1);
    endtask

    task automatic t_combine();
        set_stage(4'd0, 16'hFFFF, 16'h1111, 32'h0, 16'hFFFF, 16'h2222, 32'h0, 1'b0, 16'd1);
        set_global(5'd1, 8'd1);
        do_arm();
        step(1'b1, 16'h1111);
        check("R5 AND with only A true", trig, 1'b0);
        step(1'b1, 16'h2222);
        check("R5 AND with only B true", trig, 1'b0);
        wr(4'd0, 3'd6, {15'h0, 1'b1, 16'd1});
        do_arm();
        step(1'b1, 16'h2222);
        check("R5 OR with B true", trig, 1'b1);
    endtask

    task automatic t_count();
        set_stage(4'd0, 16'hFFFF, 16'h00C0, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 16'd3);
        set_global(5'd1, 8'd1);
        do_arm();
        step(1'b1, 16'h00C0);
        check("R6 count 1 of 3", trig, 1'b0);
        step(1'b1, 16'h0000);
        check("R6 non-matching sample", trig, 1'b0);
        step(1'b0, 16'h00C0);
        check("R6 invalid strobe ignored", trig, 1'b0);
        step(1'b1, 16'h00C0);
        check("R6 count 2 of 3", trig, 1'b0);
        step(1'b1, 16'h00C0);
        check("R6 count 3 of 3 fires", trig, 1'b1);
        wr(4'd0, 3'd6, 32'h0);
        do_arm();
        step(1'b1, 16'h00C0);
        check("R6 count 0 acts as 1", trig, 1'b1);
    endtask

    task automatic t_multi();
        set_stage(4'd0, 16'hFFFF, 16'h0001, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        set_stage(4'd1, 16'hFFFF, 16'h0002, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        set_stage(4'd2, 16'hFFFF, 16'h0003, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        set_global(5'd3, 8'd1);
        do_arm();
        step(1'b1, 16'h0002);
        check("R7 stage1 value before stage0", trig, 1'b0);
        step(1'b1, 16'h0003);
        check("R7 stage2 value before stage0", trig, 1'b0);
        step(1'b1, 16'h0001);
        step(1'b1, 16'h0003);
        check("R7 stage2 value skipped stage1", trig, 1'b0);
        step(1'b1, 16'h0002);
        check("R7 two of three stages", trig, 1'b0);
        step(1'b1, 16'h0003);
        check("R7 last stage fires", trig, 1'b1);
        step(1'b1, 16'h0000);
        step(1'b1, 16'h5555);
        check("R8 trig held after trigger", trig, 1'b1);
        do_arm();
        check("R8 arm clears trig", trig, 1'b0);
        step(1'b1, 16'h0001);
        step(1'b1, 16'h0002);
        do_arm();
        step(1'b1, 16'h0003);
        check("R9 arm restarts at stage 0", trig, 1'b0);
        step(1'b1, 16'h0001);
        step(1'b1, 16'h0002);
        step(1'b1, 16'h0003);
        check("R9 full sequence after re-arm", trig, 1'b1);
        set_global(5'd0, 8'd1);
        do_arm();
        step(1'b1, 16'h0001);
        check("R7 stage count 0 acts as 1", trig, 1'b1);
        set_global(5'd31, 8'd1);
        do_arm();
        step(1'b1, 16'h0001);
        step(1'b1, 16'h0002);
        step(1'b1, 16'h0003);
        check("R7 count above 16 needs more stages", trig, 1'b0);
    endtask

    task automatic t_nonretrig();
        settle();
        set_stage(4'd0, 16'hFFFF, 16'h0005, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 16'd1);
        set_global(5'd1, 8'd0);
        do_arm();
        step(1'b1, 16'h0005);
        check("R10 width 0 pulse high", trig_out, 1'b1);
        step(1'b0, 16'h0);
        check("R10 width 0 acts as 1", trig_out, 1'b0);
        set_global(5'd1, 8'd10);
        do_arm();
        step(1'b1, 16'h0005);
        check("R10 width 10 starts", trig_out, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0);
        do_arm();
        check("R11 arm keeps pulse running", trig_out, 1'b1);
        step(1'b1, 16'h0005);
        check("R11 second trigger sets flag", trig, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 16'h0);
            check("R11 original pulse continues", trig_out, 1'b1);
        end
        step(1'b0, 16'h0);
        check("R11 pulse not extended by retrigger", trig_out, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_level();
        t_edge();
        t_combine();
        t_count();
        t_multi();
        t_nonretrig();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule